// File: doc/BRIEF.md
# Buffered Reload PWM Pulse Generator

A single-channel pulse generator built around a 16-bit counter that counts downward. Software writes a period value and a high-time value through a small write port. Each write goes into a holding register first. The pair moves into the active compare registers only when the counter passes zero, so a period that is already running always finishes with the settings it started with. The live counter value can be read at all times. There is a run enable and a polarity select.

Software writes the period value first and the high-time value second. The high-time write arms the transfer. The next borrow moves both held values into the active registers together, and the counter reloads from the period value that has just been taken over. A high-time value larger than the period value is not allowed, and the output is undefined in that case.

Top module: `pwm_reload_gen`

## Requirements
- R1: After reset, `cnt_val` reads 0xFFFF and `pulse_o` equals `pol_inv`. The active pair after reset is period 0xFFFF and high time 0. The holding registers have no defined reset value.
- R2: While `en` is 1, the counter drops by one on each clock. When it reads 0 on an enabled clock (a borrow), it reloads from the active period value P, so one period lasts P+1 cycles.
- R3: With `pol_inv` = 0, `pulse_o` is 0 while the counter is above the active high-time value H. It is 1 while the counter is at or below H, which gives H+1 high cycles per period.
- R4: A write with `wr_sel` = 0 fills only the period holding register. It changes neither the period that is running nor the next reload, unless a write with `wr_sel` = 1 follows before that borrow.
- R5: A write with `wr_sel` = 1 fills the high-time holding register and arms a transfer. At the next borrow, both held values become active together, and the counter reloads from the new period value. Without an armed transfer, the active pair is kept.
- R6: When the period value equals the high-time value, `pulse_o` stays at `!pol_inv` for the whole period.
- R7: When `pol_inv` = 1, `pulse_o` is the inverse of the level given in R3.
- R8: While `en` is 0, the counter holds its value, no borrow or transfer happens, and `pulse_o` equals `pol_inv`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| en | input | 1 | Run enable |
| pol_inv | input | 1 | 1 inverts the output |
| wr_en | input | 1 | Write strobe |
| wr_sel | input | 1 | Write target: 0 = period holding register, 1 = high-time holding register |
| wr_data | input | 16 | Write data, always a full word |
| cnt_val | output | 16 | Live counter value |
| pulse_o | output | 1 | Pulse output |

## Verification
The hardest case to reach from the ports is a reprogramming in the middle of a period. The stimulus has to land at a known counter value, and the only sign of the transfer is the value the counter reloads with at the following borrow. The bench waits for a chosen `cnt_val` before it writes. It first writes the period value alone and checks that the next reload still uses the old period. It then writes the high-time value in mid-period and checks the reload value and the high time of the period that follows. Period length and high time are checked against values computed in the bench for a table of settings, over two periods for each setting.

// File: rtl/pwm_pkg.sv
package pwm_pkg;
  typedef enum logic {
    SEL_PERIOD = 1'b0,
    SEL_HIGH   = 1'b1
  } wr_target_e;
endpackage

// File: rtl/pwm_rst_sync.sv
module pwm_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n_in,
  output logic rst_n_out
);
  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n_in) begin
    if (!rst_n_in) sync_q <= '0;
    else           sync_q <= {sync_q[STAGES-2:0], 1'b1};
  end

  assign rst_n_out = sync_q[STAGES-1];
endmodule

// File: rtl/pwm_regbuf.sv
module pwm_regbuf
  import pwm_pkg::*;
#(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         wr_en,
  input  wr_target_e   wr_sel,
  input  logic [W-1:0] wr_data,
  input  logic         borrow,
  output logic [W-1:0] act_per,
  output logic [W-1:0] act_high,
  output logic [W-1:0] reload_val
);
  logic [W-1:0] hold_per, hold_high;
  logic         armed_q, armed_d;
  logic [W-1:0] act_per_d, act_high_d;
  logic         take;

  // holding registers: no reset, contents undefined until written
  always_ff @(posedge clk) begin
    if (wr_en && wr_sel == SEL_PERIOD) hold_per  <= wr_data;
    if (wr_en && wr_sel == SEL_HIGH)   hold_high <= wr_data;
  end

  assign take = borrow && armed_q;

  always_comb begin
    armed_d    = armed_q;
    act_per_d  = act_per;
    act_high_d = act_high;
    if (take) begin
      act_per_d  = hold_per;
      act_high_d = hold_high;
      armed_d    = 1'b0;
    end
    if (wr_en && wr_sel == SEL_HIGH) armed_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      armed_q  <= 1'b0;
      act_per  <= '1;
      act_high <= '0;
    end else begin
      armed_q  <= armed_d;
      act_per  <= act_per_d;
      act_high <= act_high_d;
    end
  end

  assign reload_val = take ? hold_per : act_per;

  // R5: pair only changes at a borrow
  a_r5_pair_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !borrow |=> ($stable(act_per) && $stable(act_high)));
  // R5: an unarmed borrow keeps the active pair
  a_r5_unarmed_keep: assert property (@(posedge clk) disable iff (!rst_n)
    (borrow && !armed_q) |=> ($stable(act_per) && $stable(act_high)));
  // R4: period-only write does not arm
  a_r4_period_no_arm: assert property (@(posedge clk) disable iff (!rst_n)
    (!armed_q && !borrow && !(wr_en && wr_sel == SEL_HIGH)) |=> !armed_q);
endmodule

// File: rtl/pwm_downcnt.sv
module pwm_downcnt #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         en,
  input  logic [W-1:0] reload_val,
  output logic         borrow,
  output logic [W-1:0] cnt
);
  logic [W-1:0] cnt_d;

  assign borrow = en && (cnt == '0);

  always_comb begin
    cnt_d = cnt;
    if (en) cnt_d = borrow ? reload_val : cnt - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt <= '1;
    else        cnt <= cnt_d;
  end

  a_r2_step_down: assert property (@(posedge clk) disable iff (!rst_n)
    (en && cnt != '0) |=> (cnt == $past(cnt) - 1'b1));
  a_r2_reload: assert property (@(posedge clk) disable iff (!rst_n)
    borrow |=> (cnt == $past(reload_val)));
  a_r8_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> $stable(cnt));
endmodule

// File: rtl/pwm_reload_gen.sv
module pwm_reload_gen
  import pwm_pkg::*;
#(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         en,
  input  logic         pol_inv,
  input  logic         wr_en,
  input  logic         wr_sel,
  input  logic [W-1:0] wr_data,
  output logic [W-1:0] cnt_val,
  output logic         pulse_o
);
  logic         rst_n_s;
  logic         borrow;
  logic [W-1:0] act_per, act_high, reload_val, cnt;
  logic         active_lvl;

  pwm_rst_sync #(.STAGES(2)) u_rst (
    .clk(clk), .rst_n_in(rst_n), .rst_n_out(rst_n_s)
  );

  pwm_regbuf #(.W(W)) u_buf (
    .clk(clk), .rst_n(rst_n_s), .wr_en(wr_en),
    .wr_sel(wr_target_e'(wr_sel)), .wr_data(wr_data), .borrow(borrow),
    .act_per(act_per), .act_high(act_high), .reload_val(reload_val)
  );

  pwm_downcnt #(.W(W)) u_cnt (
    .clk(clk), .rst_n(rst_n_s), .en(en), .reload_val(reload_val),
    .borrow(borrow), .cnt(cnt)
  );

  assign active_lvl = en && (cnt <= act_high);
  assign pulse_o    = active_lvl ^ pol_inv;
  assign cnt_val    = cnt;

  a_r3_low_above: assert property (@(posedge clk) disable iff (!rst_n_s)
    (en && !pol_inv && cnt > act_high) |-> !pulse_o);
  a_r6_equal_level: assert property (@(posedge clk) disable iff (!rst_n_s)
    (en && act_per == act_high && cnt <= act_per) |-> (pulse_o != pol_inv));
  a_r8_idle_level: assert property (@(posedge clk) disable iff (!rst_n_s)
    !en |-> (pulse_o == pol_inv));
endmodule

// File: tb/pwm_reload_gen_bench.sv
module pwm_reload_gen_bench;
  localparam int NV = 7;
  localparam logic [15:0] VP[NV] = '{16'd9, 16'd9, 16'd5, 16'd7, 16'd7, 16'd3, 16'd0};
  localparam logic [15:0] VH[NV] = '{16'd4, 16'd4, 16'd0, 16'd7, 16'd7, 16'd1, 16'd0};
  localparam logic        VI[NV] = '{1'b0, 1'b1, 1'b0, 1'b0, 1'b1, 1'b1, 1'b0};

  logic        clk = 1'b0;
  logic        rst_n, en, pol_inv, wr_en, wr_sel;
  logic [15:0] wr_data, cnt_val;
  logic        pulse_o;
  int          checks = 0, errors = 0;

  always #2 clk = ~clk;

  pwm_reload_gen u_pwm_reload_gen (
    .clk(clk), .rst_n(rst_n), .en(en), .pol_inv(pol_inv), .wr_en(wr_en),
    .wr_sel(wr_sel), .wr_data(wr_data), .cnt_val(cnt_val), .pulse_o(pulse_o)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk); #1;
  endtask

  task automatic wr(input logic sel, input logic [15:0] d);
    wr_en = 1'b1; wr_sel = sel; wr_data = d;
    step();
    wr_en = 1'b0;
  endtask

  task automatic wait_zero();
    while (cnt_val != 16'd0) step();
  endtask

  // measure one period starting with cnt_val == p
  task automatic measure(input logic [15:0] p, input logic [15:0] h, input logic inv,
                         input string req);
    int hi = 0;
    bit seq_ok = 1'b1;
    for (int k = 0; k <= int'(p); k++) begin
      if (cnt_val != 16'(int'(p) - k)) seq_ok = 1'b0;
      if ((pulse_o ^ inv) == 1'b1) hi++;
      step();
    end
    chk(seq_ok, "R2 countdown", 0, 0);
    chk(cnt_val == p, "R2 period reload", cnt_val, p);
    chk(hi == int'(h) + 1, req, hi, int'(h) + 1);
  endtask

  task automatic run_vec(input logic [15:0] p, input logic [15:0] h, input logic inv);
    string req;
    pol_inv = inv;
    wr(1'b0, p);
    wr(1'b1, h);
    wait_zero();
    step();
    chk(cnt_val == p, "R5 transfer on borrow", cnt_val, p);
    if (p == h)  req = "R6 equal high time";
    else if (inv) req = "R7 inverted high time";
    else          req = "R3 high time";
    measure(p, h, inv, req);
    measure(p, h, inv, req);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [15:0] held;
    rst_n = 1'b0; en = 1'b0; pol_inv = 1'b0;
    wr_en = 1'b0; wr_sel = 1'b0; wr_data = '0;
    step(); step();
    rst_n = 1'b1;
    step(); step(); step();
    // R1 reset state
    chk(cnt_val == 16'hFFFF, "R1 reset count", cnt_val, 16'hFFFF);
    chk(pulse_o == 1'b0, "R1 reset output", pulse_o, 0);
    en = 1'b1;
    step(); step(); step();
    chk(cnt_val == 16'hFFFC, "R2 first decrements", cnt_val, 16'hFFFC);

    // vector table
    for (int i = 0; i < NV; i++) run_vec(VP[i], VH[i], VI[i]);

    // mid-period reprogramming
    run_vec(16'd9, 16'd4, 1'b0);
    while (cnt_val != 16'd6) step();
    wr(1'b0, 16'd5);
    chk(cnt_val == 16'd5, "R4 running period undisturbed", cnt_val, 5);
    wait_zero(); step();
    chk(cnt_val == 16'd9, "R4 period-only write not taken", cnt_val, 9);
    measure(16'd9, 16'd4, 1'b0, "R4 old high time kept");
    while (cnt_val != 16'd5) step();
    wr(1'b1, 16'd2);
    chk(cnt_val == 16'd4, "R5 no early transfer", cnt_val, 4);
    wait_zero(); step();
    chk(cnt_val == 16'd5, "R5 pair taken at borrow", cnt_val, 5);
    measure(16'd5, 16'd2, 1'b0, "R5 new high time");

    // disable behaviour
    step(); step();
    held = cnt_val;
    en = 1'b0;
    step(); step(); step(); step();
    chk(cnt_val == held, "R8 counter holds", cnt_val, held);
    chk(pulse_o == 1'b0, "R8 idle level normal", pulse_o, 0);
    pol_inv = 1'b1;
    #1;
    chk(pulse_o == 1'b1, "R8 idle level inverted", pulse_o, 1);
    pol_inv = 1'b0;
    en = 1'b1;
    step();
    chk(cnt_val == held - 16'd1, "R8 resume", cnt_val, held - 16'd1);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule